// File: doc/BRIEF.md
# Banked Dual-Port RAM (128 x 8)

This block is a 128-word by 8-bit memory with one write port and one read port, assembled from a grid of small storage banks, each 32 words by 4 bits. Two banks side by side share address and control and hold the low and high nibble of a word; four such rows stacked give the full depth. The two top address bits pick the row: on the write side they are decoded into one write enable per row, on the read side they steer one row's output onto the read bus.

A write is captured (enable, address, data) into registers on the rising clock edge and committed to the array on the following falling edge, half a cycle later. The read side has no clock: read data follows the read address combinationally. A read enable releases the read bus, shown here as all-zero data with a separate valid flag low. Driving the read and write addresses from the same 7-bit source gives a synchronous single-port memory. Holding the write enable low turns the block into a ROM whose contents come from the reset-time initialisation parameters.

Top module: `banked_dpram`

## Requirements
- R1: Write enable, write address and write data are sampled on the rising clock edge; changes on those inputs after that edge do not alter the write that was sampled.
- R2: A sampled write reaches the array on the falling edge that follows its capture edge; until that falling edge a read of the written address returns the previous contents, and after it returns the new data.
- R3: Read data follows the read address with no clock edge in between.
- R4: Each word is split across two 4-bit banks: data bits [3:0] are held in one bank and bits [7:4] in the other, and both nibbles are written and read together.
- R5: Write address bits [6:5] select which of the four 32-word rows is written; exactly one row is written per enabled write and the other rows keep their contents, including across the word pairs 31/32, 63/64 and 95/96.
- R6: Read address bits [6:5] select which row drives the read data, and bits [4:0] the word within that row.
- R7: While read enable is low, read data is 0x00 and read valid is low; while it is high, read valid is high and read data is the addressed word. Writes proceed regardless of read enable.
- R8: With the read address equal to the write address, a write is readable at that address from the falling edge after its capture on, as a synchronous single-port memory.
- R9: While write enable is low at the capture edge, no word changes whatever the write address and write data are.
- R10: While rst_n is low, word i holds (INIT_BASE + i*INIT_STEP) mod 256 and the write pipeline is cleared, so no write occurs during reset or in the cycles after its release unless write enable is driven high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge captures writes, falling edge commits them |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write enable, sampled on the rising edge |
| wr_addr | input | 7 | Write word address; bits [6:5] select the row |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read enable; low releases the read bus |
| rd_addr | input | 7 | Read word address; bits [6:5] select the row |
| rd_data | output | 8 | Read data, combinational from rd_addr; 0x00 when released |
| rd_valid | output | 1 | High while the read bus is driven |

## Verification
On every cycle the assertions check that a released read bus is zero with valid low, that no more than one row receives a write enable, that a disabled write at the capture edge leaves the pipeline empty, and that a bank's contents stay fixed across any falling edge that carries no write for it. Only the bench's scenarios can show the half-cycle ordering of capture and commit seen from the read port, the row decode at the 31/32, 63/64 and 95/96 boundaries, the nibble split, the initial contents, and the tied-address single-port use, all compared against a behavioural 128-entry model sampled before the capture edge, between the edges and after the commit edge.

// File: rtl/banked_dpram_pkg.sv
`timescale 1ns/1ps
package banked_dpram_pkg;

  // Initial content of a word: linear fill, truncated by the caller.
  function automatic logic [31:0] init_word(input int unsigned idx,
                                            input logic [31:0] base,
                                            input logic [31:0] step);
    return base + idx * step;
  endfunction

endpackage

// File: rtl/bdp_rst_sync.sv
`timescale 1ns/1ps
module bdp_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/bdp_wr_stage.sv
`timescale 1ns/1ps
module bdp_wr_stage #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  logic [DATA_W-1:0] wd_i,
  output logic              we_q,
  output logic [ADDR_W-1:0] wa_q,
  output logic [DATA_W-1:0] wd_q
);
  logic              we_d;
  logic [ADDR_W-1:0] wa_d;
  logic [DATA_W-1:0] wd_d;

  // Address and data only load when a write is requested.
  always_comb begin
    we_d = we_i;
    wa_d = wa_q;
    wd_d = wd_q;
    if (we_i) begin
      wa_d = wa_i;
      wd_d = wd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b0;
      wa_q <= '0;
      wd_q <= '0;
    end else begin
      we_q <= we_d;
      wa_q <= wa_d;
      wd_q <= wd_d;
    end
  end

  // R9
  no_spurious_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> !we_q);
endmodule

// File: rtl/bdp_bank.sv
`timescale 1ns/1ps
module bdp_bank #(
  parameter int unsigned AW        = 5,
  parameter int unsigned NW        = 4,
  parameter int unsigned ROW       = 0,
  parameter int unsigned COL       = 0,
  parameter logic [31:0] INIT_BASE = 32'h0,
  parameter logic [31:0] INIT_STEP = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [NW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [NW-1:0] rd_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0][NW-1:0] mem_q;
  logic [DEPTH-1:0][NW-1:0] mem_d;

  function automatic logic [NW-1:0] init_nib(input int unsigned idx);
    logic [31:0] w;
    w = banked_dpram_pkg::init_word(ROW * DEPTH + idx, INIT_BASE, INIT_STEP);
    return w[COL*NW +: NW];
  endfunction

  always_comb begin
    mem_d = mem_q;
    if (we_i) mem_d[wa_i] = wd_i;
  end

  // Commit on the falling edge, half a cycle after capture.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned i = 0; i < DEPTH; i++) mem_q[AW'(i)] <= init_nib(i);
    end else begin
      mem_q <= mem_d;
    end
  end

  // Asynchronous read.
  assign rd_o = mem_q[ra_i];

  // R2 / R9
  bank_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/banked_dpram.sv
`timescale 1ns/1ps
module banked_dpram #(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BANK_AW   = 5,
  parameter int unsigned NIB_W     = 4,
  parameter logic [31:0] INIT_BASE = 32'h0,
  parameter logic [31:0] INIT_STEP = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int unsigned ROW_AW = ADDR_W - BANK_AW;
  localparam int unsigned ROWS   = 1 << ROW_AW;
  localparam int unsigned COLS   = DATA_W / NIB_W;

  logic              rst_n_s;
  logic              we_q;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;
  logic [ROWS-1:0]   row_we;
  logic [ROWS-1:0][DATA_W-1:0] row_rd;
  logic [DATA_W-1:0] sel_word;

  bdp_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  bdp_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we_i  (wr_en),
    .wa_i  (wr_addr),
    .wd_i  (wr_data),
    .we_q  (we_q),
    .wa_q  (wa_q),
    .wd_q  (wd_q)
  );

  // Row write enables from the captured address MSBs.
  always_comb begin
    row_we = '0;
    if (we_q) row_we[wa_q[ADDR_W-1 -: ROW_AW]] = 1'b1;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      bdp_bank #(
        .AW        (BANK_AW),
        .NW        (NIB_W),
        .ROW       (r),
        .COL       (c),
        .INIT_BASE (INIT_BASE),
        .INIT_STEP (INIT_STEP)
      ) u_bank (
        .clk   (clk),
        .rst_n (rst_n_s),
        .we_i  (row_we[r]),
        .wa_i  (wa_q[BANK_AW-1:0]),
        .wd_i  (wd_q[c*NIB_W +: NIB_W]),
        .ra_i  (rd_addr[BANK_AW-1:0]),
        .rd_o  (row_rd[r][c*NIB_W +: NIB_W])
      );
    end
  end

  // Row select on the read address MSBs, then bus release.
  always_comb begin
    sel_word = row_rd[rd_addr[ADDR_W-1 -: ROW_AW]];
    rd_data  = rd_en ? sel_word : '0;
    rd_valid = rd_en;
  end

  // R5
  one_row_wr_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(row_we));

  // R7
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_en |-> (rd_data == '0) && !rd_valid);

  // R7
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_en |-> rd_valid);
endmodule

// File: tb/banked_dpram_tb.sv
`timescale 1ns/1ps
module banked_dpram_tb;
  localparam logic [31:0] IB = 32'h5A;
  localparam logic [31:0] IS = 32'h03;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       rd_valid;

  logic [7:0] ref_mem [128];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  banked_dpram #(.INIT_BASE(IB), .INIT_STEP(IS)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check_read(input string req);
    logic [7:0] exp_d;
    exp_d = rd_en ? ref_mem[rd_addr] : 8'h00;
    n_tests++;
    if (rd_data !== exp_d || rd_valid !== rd_en) begin
      n_fail++;
      $display("FAIL %s addr=%0d rd_data=%02h valid=%b expected %02h valid=%b",
               req, rd_addr, rd_data, rd_valid, exp_d, rd_en);
    end
  endtask

  // One clock cycle, entered just after a falling edge.
  task automatic step(input logic we, input int wa, input logic [7:0] wd,
                      input logic re, input int ra, input string req);
    logic       p_we;
    logic [6:0] p_wa;
    logic [7:0] p_wd;
    wr_en = we; wr_addr = 7'(wa); wr_data = wd;
    rd_en = re; rd_addr = 7'(ra);
    #4 check_read({req, " pre-capture"});
    @(posedge clk);
    p_we = we; p_wa = 7'(wa); p_wd = wd;
    #2;
    wr_addr = 7'(wa) ^ 7'h55;          // R1: disturb after capture
    wr_data = ~wd;
    #2 check_read({req, " R2 old before commit"});
    @(negedge clk);
    if (p_we) ref_mem[p_wa] = p_wd;
    #2 check_read({req, " after commit"});
  endtask

  task automatic sweep(input string req);
    rd_en = 1'b1;
    for (int i = 0; i < 128; i++) begin
      rd_addr = 7'(i);
      #0.1 check_read(req);
    end
  endtask

  initial begin
    for (int i = 0; i < 128; i++) ref_mem[i] = 8'(IB + i * IS);

    // R10: contents during reset
    repeat (3) @(negedge clk);
    #2 sweep("R10 init contents in reset");
    rd_en = 1'b0; rd_addr = 7'd40;
    #1 check_read("R7 released in reset");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;

    // R10: pipeline cleared, idle cycles write nothing
    step(1'b0, 0, 8'h00, 1'b1, 0, "R10 idle after reset");
    step(1'b0, 0, 8'h00, 1'b1, 127, "R10 idle after reset");

    // R5 / R8: boundary words with tied addresses
    step(1'b1, 31,  8'h11, 1'b1, 31,  "R5 R8 addr31");
    step(1'b1, 32,  8'h22, 1'b1, 32,  "R5 R8 addr32");
    step(1'b1, 63,  8'h33, 1'b1, 63,  "R5 R8 addr63");
    step(1'b1, 64,  8'h44, 1'b1, 64,  "R5 R8 addr64");
    step(1'b1, 95,  8'h55, 1'b1, 95,  "R5 R8 addr95");
    step(1'b1, 96,  8'h66, 1'b1, 96,  "R5 R8 addr96");
    step(1'b1, 0,   8'h77, 1'b1, 0,   "R5 R8 addr0");
    step(1'b1, 127, 8'h88, 1'b1, 127, "R5 R8 addr127");

    // R5 / R6: back-to-back writes to different rows, reading another row
    step(1'b1, 5,   8'hA1, 1'b1, 101, "R5 R6 b2b row0");
    step(1'b1, 37,  8'hA2, 1'b1, 5,   "R5 R6 b2b row1");
    step(1'b1, 69,  8'hA3, 1'b1, 37,  "R5 R6 b2b row2");
    step(1'b1, 101, 8'hA4, 1'b1, 69,  "R5 R6 b2b row3");
    step(1'b0, 0,   8'h00, 1'b1, 101, "R6 readback row3");

    // R3: asynchronous read, several addresses in one low phase
    rd_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      rd_addr = 7'(i * 32 + 5);
      #1 check_read("R3 async read");
    end
    @(negedge clk); #1;

    // R4: nibble independence
    step(1'b1, 50, 8'hF0, 1'b1, 50, "R4 high nibble");
    step(1'b1, 50, 8'h0F, 1'b1, 50, "R4 low nibble");
    step(1'b1, 51, 8'hC3, 1'b1, 50, "R4 neighbour");

    // R9: writes disabled, address/data toggling
    for (int i = 0; i < 8; i++)
      step(1'b0, i * 17, 8'(i * 29 + 1), 1'b1, i * 17, "R9 write disabled");

    // R7: released bus while writing
    step(1'b1, 10, 8'h5C, 1'b0, 10, "R7 released write");
    step(1'b0, 0,  8'h00, 1'b1, 10, "R7 write landed");

    // Mixed traffic
    for (int i = 0; i < 300; i++) begin
      int a;
      a = int'($urandom_range(0, 127));
      step(1'($urandom_range(0, 1)), a, 8'($urandom), 1'($urandom_range(0, 3) != 0),
           ((i % 3) == 0) ? a : int'($urandom_range(0, 127)), "R1 R2 R6 mixed");
    end

    sweep("R6 final sweep");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule